// File: doc/BRIEF.md
# Per-Channel Inrush Chopping Limiter

This block sits between the commanded state of eight switched power outputs and the gate drive of those outputs. Each channel receives a commanded-on bit (typically an output latch already gated by a global blanking control) and a digital overcurrent flag from an external comparator. The block then produces the gate-on signal that actually switches the channel. When a conducting channel draws too much current, as a cold lamp filament does at turn-on, the block does not shut the channel down. It cycles the channel through a long off window and a short on window, and repeats this until an on window passes without an overcurrent. The channel then returns to steady conduction. The load therefore turns on later, but its inrush current stays capped. There is no fault shutdown.

Each channel has its own comparator synchronizer, glitch filter, window timer and state machine, so one chopping channel never disturbs the others. The on-window and off-window lengths are parameters in system clock cycles. The off window should be longer than the four-cycle flag path, so that a comparator that is still high when the drive turns off has cleared before the next on window. A second output vector reports which channels are currently in the chopping cycle.

Top module: `chop_limiter`

## Requirements
- R1: A channel whose command bit is low has its gate output low in that same cycle, with no clock edge needed, whatever its chopping state.
- R2: A commanded channel that is idle and sees no qualified overcurrent drives its gate high after the first rising edge at which its command is high, with its chopping bit low.
- R3: The overcurrent flag counts only when it is high at two consecutive rising edges k and k+1. For a steadily conducting channel, the gate then goes low and the chopping bit (1 = channel is in the chopping cycle) goes high after edge k+3. A flag that is high at a single edge has no effect.
- R4: An off window holds the gate low for exactly OFF_CYCLES cycles. The channel then drives its gate high for an on window while its chopping bit stays high.
- R5: A qualified overcurrent during an on window ends that window at the next edge and starts a new off window of full length. A flag that stays high therefore repeats the off/on cycle.
- R6: An on window that lasts ON_CYCLES cycles with no qualified overcurrent returns the channel to steady conduction: gate high, chopping bit low.
- R7: A low command at a rising edge sends the channel to idle, with its chopping bit low after that edge and its timer cleared. If the channel is commanded again with no overcurrent, it conducts steadily after one edge and does not resume chopping.
- R8: Channels are independent. Chopping on one channel leaves the gate and chopping bits of the other channels unchanged.
- R9: While the active-low reset is asserted, all gate and chopping bits are low.
- R10: An overcurrent flag on a channel that is not commanded has no effect: the channel's gate and chopping bits stay low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous reset, active low |
| cmdOn | input | NUM_CH | Commanded-on bit per channel |
| ocFlag | input | NUM_CH | Asynchronous overcurrent flag per channel, high = over limit |
| gateOn | output | NUM_CH | Gate drive per channel, high = conducting |
| chopping | output | NUM_CH | High while the channel is in its off or on chopping window |

## Verification
A channel stuck in the wrong state shows as a gate that is high during what should be an off window, or a chopping bit that stays high after a clean on window. Both appear at the ports on the first edge after the transition that went wrong. A timer that is miscounted or not cleared moves the return of the gate by one or more cycles, so every off and on window is compared cycle by cycle. A broken filter shows as chopping that starts one cycle early or late, or starts after a single-cycle glitch. A command path fault shows as the gate staying high in the same cycle after the command is removed.

// File: rtl/chop_pkg.sv
package chop_pkg;

  typedef enum logic [1:0] {
    CH_IDLE      = 2'd0,
    CH_STEADY    = 2'd1,
    CH_PULSE_OFF = 2'd2,
    CH_PULSE_ON  = 2'd3
  } chanState_t;

  typedef struct packed {
    logic clear;
    logic loadOff;
    logic loadOn;
  } timerCmd_t;

endpackage

// File: rtl/oc_filter.sv
module oc_filter #(
  parameter int SYNC_STAGES = 2,
  parameter int CONFIRM     = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic flagIn,
  output logic qualOut
);

  logic [SYNC_STAGES-1:0] syncQ;
  logic [CONFIRM-2:0]     histQ;
  logic [CONFIRM-1:0]     window;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncQ <= '0;
    end else begin
      syncQ <= {syncQ[SYNC_STAGES-2:0], flagIn};
    end
  end

  // newest synchronized sample plus the previous CONFIRM-1 samples
  assign window = {histQ, syncQ[SYNC_STAGES-1]};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      histQ <= '0;
    end else begin
      histQ <= window[CONFIRM-2:0];
    end
  end

  assign qualOut = &window;

endmodule

// File: rtl/chop_timer.sv
module chop_timer
  import chop_pkg::*;
#(
  parameter int ON_CYCLES  = 2000,
  parameter int OFF_CYCLES = 125000
) (
  input  logic      clk,
  input  logic      rstN,
  input  timerCmd_t cmd,
  output logic      zero
);

  localparam int MAX_WIN = (ON_CYCLES > OFF_CYCLES) ? ON_CYCLES : OFF_CYCLES;
  localparam int CNT_W   = $clog2(MAX_WIN + 1);
  localparam logic [CNT_W-1:0] ON_LOAD  = CNT_W'(ON_CYCLES - 1);
  localparam logic [CNT_W-1:0] OFF_LOAD = CNT_W'(OFF_CYCLES - 1);

  logic [CNT_W-1:0] count;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      count <= '0;
    end else if (cmd.clear) begin
      count <= '0;
    end else if (cmd.loadOff) begin
      count <= OFF_LOAD;
    end else if (cmd.loadOn) begin
      count <= ON_LOAD;
    end else if (count != '0) begin
      count <= count - 1'b1;
    end
  end

  assign zero = (count == '0);

endmodule

// File: rtl/chop_datapath.sv
module chop_datapath
  import chop_pkg::*;
#(
  parameter int NUM_CH      = 8,
  parameter int ON_CYCLES   = 2000,
  parameter int OFF_CYCLES  = 125000,
  parameter int SYNC_STAGES = 2,
  parameter int CONFIRM     = 2
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic      [NUM_CH-1:0] ocFlag,
  input  timerCmd_t [NUM_CH-1:0] timerCmd,
  output logic      [NUM_CH-1:0] ocQual,
  output logic      [NUM_CH-1:0] timerZero
);

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_lane
    oc_filter #(
      .SYNC_STAGES(SYNC_STAGES),
      .CONFIRM    (CONFIRM)
    ) u_filter (
      .clk    (clk),
      .rstN   (rstN),
      .flagIn (ocFlag[ch]),
      .qualOut(ocQual[ch])
    );

    chop_timer #(
      .ON_CYCLES (ON_CYCLES),
      .OFF_CYCLES(OFF_CYCLES)
    ) u_timer (
      .clk (clk),
      .rstN(rstN),
      .cmd (timerCmd[ch]),
      .zero(timerZero[ch])
    );
  end

endmodule

// File: rtl/chop_control.sv
module chop_control
  import chop_pkg::*;
#(
  parameter int NUM_CH = 8
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic      [NUM_CH-1:0] cmdOn,
  input  logic      [NUM_CH-1:0] ocQual,
  input  logic      [NUM_CH-1:0] timerZero,
  output timerCmd_t [NUM_CH-1:0] timerCmd,
  output logic      [NUM_CH-1:0] gateOn,
  output logic      [NUM_CH-1:0] chopping
);

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_fsm
    chanState_t state;
    chanState_t stateNext;
    timerCmd_t  tcmd;

    always_comb begin
      stateNext = state;
      tcmd      = '0;
      if (!cmdOn[ch]) begin
        stateNext  = CH_IDLE;
        tcmd.clear = 1'b1;
      end else begin
        unique case (state)
          CH_IDLE: stateNext = CH_STEADY;
          CH_STEADY: begin
            if (ocQual[ch]) begin
              stateNext    = CH_PULSE_OFF;
              tcmd.loadOff = 1'b1;
            end
          end
          CH_PULSE_OFF: begin
            if (timerZero[ch]) begin
              stateNext   = CH_PULSE_ON;
              tcmd.loadOn = 1'b1;
            end
          end
          CH_PULSE_ON: begin
            // overcurrent wins over a window that ends in the same cycle
            if (ocQual[ch]) begin
              stateNext    = CH_PULSE_OFF;
              tcmd.loadOff = 1'b1;
            end else if (timerZero[ch]) begin
              stateNext = CH_STEADY;
            end
          end
          default: stateNext = CH_IDLE;
        endcase
      end
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        state <= CH_IDLE;
      end else begin
        state <= stateNext;
      end
    end

    assign timerCmd[ch] = tcmd;
    assign gateOn[ch]   = cmdOn[ch] &
                          ((state == CH_STEADY) || (state == CH_PULSE_ON));
    assign chopping[ch] = (state == CH_PULSE_ON) || (state == CH_PULSE_OFF);
  end

endmodule

// File: rtl/chop_limiter.sv
module chop_limiter
  import chop_pkg::*;
#(
  parameter int NUM_CH     = 8,
  parameter int ON_CYCLES  = 2000,
  parameter int OFF_CYCLES = 125000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [NUM_CH-1:0] cmdOn,
  input  logic [NUM_CH-1:0] ocFlag,
  output logic [NUM_CH-1:0] gateOn,
  output logic [NUM_CH-1:0] chopping
);

  localparam int SYNC_STAGES = 2;
  localparam int CONFIRM     = 2;

  timerCmd_t [NUM_CH-1:0] timerCmd;
  logic      [NUM_CH-1:0] ocQual;
  logic      [NUM_CH-1:0] timerZero;

  chop_datapath #(
    .NUM_CH     (NUM_CH),
    .ON_CYCLES  (ON_CYCLES),
    .OFF_CYCLES (OFF_CYCLES),
    .SYNC_STAGES(SYNC_STAGES),
    .CONFIRM    (CONFIRM)
  ) u_datapath (
    .clk      (clk),
    .rstN     (rstN),
    .ocFlag   (ocFlag),
    .timerCmd (timerCmd),
    .ocQual   (ocQual),
    .timerZero(timerZero)
  );

  chop_control #(
    .NUM_CH(NUM_CH)
  ) u_control (
    .clk      (clk),
    .rstN     (rstN),
    .cmdOn    (cmdOn),
    .ocQual   (ocQual),
    .timerZero(timerZero),
    .timerCmd (timerCmd),
    .gateOn   (gateOn),
    .chopping (chopping)
  );

endmodule

// File: rtl/chop_limiter_checks.sv
module chop_limiter_checks #(
  parameter int NUM_CH = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic [NUM_CH-1:0] cmdOn,
  input logic [NUM_CH-1:0] ocFlag,
  input logic [NUM_CH-1:0] gateOn,
  input logic [NUM_CH-1:0] chopping
);

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chk
    // R1: no drive without a command
    p_gate_needs_cmd_r1: assert property (@(posedge clk) disable iff (!rstN)
      !cmdOn[ch] |-> !gateOn[ch]);

    // R7: command removal leaves the chopping cycle at the next edge
    p_idle_on_drop_r7: assert property (@(posedge clk) disable iff (!rstN)
      !cmdOn[ch] |=> !chopping[ch]);

    // R4: every entry into chopping starts with the gate off
    p_entry_is_off_r4: assert property (@(posedge clk) disable iff (!rstN)
      $rose(chopping[ch]) |-> !gateOn[ch]);

    // R3: chopping starts only after two consecutive high flag samples
    p_two_samples_r3: assert property (@(posedge clk) disable iff (!rstN)
      $rose(chopping[ch]) |-> ($past(ocFlag[ch], 3) && $past(ocFlag[ch], 4)));

    // R6: leaving chopping while still commanded means steady conduction
    p_exit_conducts_r6: assert property (@(posedge clk) disable iff (!rstN)
      ($fell(chopping[ch]) && $past(cmdOn[ch]) && cmdOn[ch]) |-> gateOn[ch]);
  end

endmodule

bind chop_limiter chop_limiter_checks #(.NUM_CH(NUM_CH)) u_checks (
  .clk     (clk),
  .rstN    (rstN),
  .cmdOn   (cmdOn),
  .ocFlag  (ocFlag),
  .gateOn  (gateOn),
  .chopping(chopping)
);

// File: tb/tb_chop_limiter.sv
module tb_chop_limiter;

  localparam int CLK_PERIOD = 10;
  localparam int NCH        = 8;
  localparam int ON_W       = 4;
  localparam int OFF_W      = 5;
  localparam int NROWS      = 25;

  // {cmdOn, ocFlag, expected gateOn, expected chopping}
  // ch0: on, overcurrent, off window, on window cut short (R5), clean window (R6), drop
  // ch1: flag high but never commanded (R10); ch2: steady throughout (R8)
  localparam logic [31:0] ROWS [NROWS] = '{
    32'h00020000, 32'h05020500, 32'h05030500, 32'h05030500, 32'h05020500,
    32'h05020401, 32'h05020401, 32'h05020401, 32'h05020401, 32'h05020401,
    32'h05030501, 32'h05030501, 32'h05020501, 32'h05020401, 32'h05020401,
    32'h05020401, 32'h05020401, 32'h05020401, 32'h05020501, 32'h05020501,
    32'h05020501, 32'h05020501, 32'h05020500, 32'h04020400, 32'h04020400
  };

  logic           clk = 1'b0;
  logic           rstN = 1'b0;
  logic [NCH-1:0] cmdOn = '0;
  logic [NCH-1:0] ocFlag = '0;
  logic [NCH-1:0] gateOn;
  logic [NCH-1:0] chopping;

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  chop_limiter #(
    .NUM_CH    (NCH),
    .ON_CYCLES (ON_W),
    .OFF_CYCLES(OFF_W)
  ) dut (
    .clk     (clk),
    .rstN    (rstN),
    .cmdOn   (cmdOn),
    .ocFlag  (ocFlag),
    .gateOn  (gateOn),
    .chopping(chopping)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic step();
    @(posedge clk);
    #2;
  endtask

  task automatic check(string req, string what, logic [NCH-1:0] act, logic [NCH-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    // R9: reset with every channel commanded
    cmdOn = '1;
    step();
    step();
    check("R9", "gate in reset", gateOn, '0);
    check("R9", "chop in reset", chopping, '0);
    cmdOn = '0;
    rstN  = 1'b1;

    // table walk: R2 R3 R4 R5 R6 R7 R8 R10
    for (int i = 0; i < NROWS; i++) begin
      cmdOn  = ROWS[i][31:24];
      ocFlag = ROWS[i][23:16];
      step();
      check("R4_R5_R6", $sformatf("row %0d gate", i), gateOn, ROWS[i][15:8]);
      check("R3_R8_R10", $sformatf("row %0d chop", i), chopping, ROWS[i][7:0]);
    end

    // reset again mid-run
    cmdOn = 8'hFF; ocFlag = 8'h00; rstN = 1'b0;
    step();
    check("R9", "gate in second reset", gateOn, '0);
    check("R9", "chop in second reset", chopping, '0);
    cmdOn = '0; rstN = 1'b1;
    step();

    // R7: drop the command during an off window, then command again
    cmdOn = 8'h08;
    step();
    check("R2", "ch3 turns on", gateOn, 8'h08);
    ocFlag = 8'h08; step(); step();
    ocFlag = 8'h00; step();
    check("R3", "ch3 still on before qualify", gateOn, 8'h08);
    step();
    check("R3", "ch3 gate off on chop", gateOn, 8'h00);
    check("R3", "ch3 chopping", chopping, 8'h08);
    cmdOn = 8'h00; step();
    check("R7", "ch3 chop cleared", chopping, 8'h00);
    cmdOn = 8'h08; step();
    check("R7", "ch3 re-on steady", gateOn, 8'h08);
    check("R7", "ch3 re-on not chopping", chopping, 8'h00);
    for (int k = 0; k < 3; k++) begin
      step();
      check("R7", "ch3 stays steady", {gateOn[3], chopping[3]}, 2'b10);
    end

    // R3: one-cycle glitch is rejected
    ocFlag = 8'h08; step();
    ocFlag = 8'h00;
    for (int k = 0; k < 5; k++) begin
      step();
      check("R3", "glitch ignored", chopping, 8'h00);
    end
    check("R3", "glitch gate", gateOn, 8'h08);

    // R10: flag on uncommanded ch5
    ocFlag = 8'h20;
    for (int k = 0; k < 6; k++) begin
      step();
      check("R10", "uncommanded gate", gateOn, 8'h08);
      check("R10", "uncommanded chop", chopping, 8'h00);
    end

    // R4 R5: persistent overcurrent on ch0, flag raised with the command
    cmdOn = 8'h01; ocFlag = 8'h01;
    for (int k = 1; k <= 15; k++) begin
      logic expG;
      logic expC;
      step();
      expG = (k <= 3) || (k == 9) || (k == 15);
      expC = (k >= 4);
      check("R4_R5", $sformatf("persist step %0d gate", k), gateOn, {7'b0, expG});
      check("R4_R5", $sformatf("persist step %0d chop", k), chopping, {7'b0, expC});
    end

    // R1: command drop during an on window blanks the gate without an edge
    cmdOn = 8'h00;
    #1;
    check("R1", "gate blanks same cycle", gateOn, 8'h00);
    step();
    check("R7", "chop cleared after drop", chopping, 8'h00);

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule